// File: doc/BRIEF.md
# Receive Gap Timer

This block is a down-counting timer with two ways of being driven. In normal mode, software start and stop pulses control it: a start loads the preload value and counting begins, one step per enable tick. When the count runs out, a ready flag rises and the counter reloads itself to run again. In receive-timeout mode, the start and stop pulses have no effect. Instead, each character the receiver moves into its holding register reloads the counter and starts it again. If no further character arrives before the count runs out, the counter halts at zero and raises ready. That flag then signals a gap in the incoming data.

Switching timeout mode on halts the counter and drops any pending ready flag. Switching it off only hands control back to the start and stop pulses. A running count keeps running, and a pending ready stays set. A separate clear input drops the ready flag. The receiver and any interrupt masking live outside this block.

Top module: `rx_gap_timer`

## Requirements
- R1: After reset, count is 0, ready is 0, the counter is halted and normal mode is active.
- R2: In normal mode a start pulse loads preload into count. While running, count drops by exactly one on each cycle with tick high, and it holds on cycles without tick.
- R3: In normal mode, a tick arriving while running with count at 1 or 0 sets ready and reloads count from preload. Counting then continues.
- R4: In normal mode a stop pulse halts the counter, keeps count, and clears ready. When start and stop arrive in the same cycle, stop wins.
- R5: A timeout-on pulse enters timeout mode, halts the counter, keeps count and clears ready. It overrides every other input in that cycle.
- R6: While timeout mode is active, start and stop pulses change neither count, the running state nor ready.
- R7: While timeout mode is active, a character-transfer pulse loads preload into count and starts the counter. In normal mode that pulse has no effect.
- R8: In timeout mode, a tick arriving while running with count at 1 or 0 sets ready, sets count to 0 and halts. Count stays 0 until the next character-transfer pulse.
- R9: A timeout-off pulse returns to normal mode without halting a running count and without clearing ready. Start and stop pulses act again from the next cycle.
- R10: A ready-clear pulse clears ready, except in a cycle where the counter expires; in that cycle ready ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| preload | input | CNT_W | Reload value |
| startCmd | input | 1 | Normal-mode start pulse |
| stopCmd | input | 1 | Normal-mode stop pulse |
| toOnCmd | input | 1 | Enter timeout mode |
| toOffCmd | input | 1 | Leave timeout mode |
| charXfer | input | 1 | Receiver moved a character into its holding register |
| readyClr | input | 1 | Clear the ready flag |
| ready | output | 1 | Count expired |
| count | output | CNT_W | Current count |

## Verification
The assertions assume that every command input is a single-cycle pulse sampled on the clock, and that preload is steady whenever a load can happen. The stimulus drives every input on the falling edge. It holds preload constant throughout each sweep step. Pulses are raised for exactly one cycle, alone or in deliberate same-cycle combinations, so that the precedence of timeout-on, stop and expiry is exercised.

// File: rtl/rx_gap_timer_pkg.sv
package rx_gap_timer_pkg;
  typedef struct packed {
    logic load;
    logic dec;
    logic zero;
  } cntStrobe_t;
endpackage

// File: rtl/rx_gap_timer_ctrl.sv
module rx_gap_timer_ctrl
  import rx_gap_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       startCmd,
  input  logic       stopCmd,
  input  logic       toOnCmd,
  input  logic       toOffCmd,
  input  logic       charXfer,
  input  logic       readyClr,
  input  logic       cntLast,
  output cntStrobe_t strobe,
  output logic       ready,
  output logic       running,
  output logic       toMode
);
  logic normLoad, normStop, toLoad, anyLoad, advance, expire;

  always_comb begin
    normLoad = ~toMode & startCmd & ~stopCmd & ~toOnCmd;
    normStop = ~toMode & stopCmd & ~toOnCmd;
    toLoad   = toMode & charXfer & ~toOnCmd;
    anyLoad  = normLoad | toLoad;
    advance  = running & tick & ~anyLoad & ~normStop & ~toOnCmd;
    expire   = advance & cntLast;
    strobe.load = anyLoad | (expire & ~toMode);
    strobe.dec  = advance & ~cntLast;
    strobe.zero = expire & toMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      ready   <= 1'b0;
      toMode  <= 1'b0;
    end else begin
      if (toOnCmd) begin
        running <= 1'b0;
        ready   <= 1'b0;
        toMode  <= 1'b1;
      end else begin
        if (anyLoad)
          running <= 1'b1;
        else if (normStop || (expire && toMode))
          running <= 1'b0;
        if (expire)
          ready <= 1'b1;
        else if (normStop || readyClr)
          ready <= 1'b0;
        if (toOffCmd)
          toMode <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_gap_timer_dp.sv
module rx_gap_timer_dp
  import rx_gap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             cntLast
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign cntLast = (count <= ONE);

  always_ff @(posedge clk) begin
    if (!rstN)
      count <= '0;
    else if (strobe.load)
      count <= preload;
    else if (strobe.zero)
      count <= '0;
    else if (strobe.dec)
      count <= count - ONE;
  end
endmodule

// File: rtl/rx_gap_timer.sv
module rx_gap_timer
  import rx_gap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CNT_W-1:0] preload,
  input  logic             startCmd,
  input  logic             stopCmd,
  input  logic             toOnCmd,
  input  logic             toOffCmd,
  input  logic             charXfer,
  input  logic             readyClr,
  output logic             ready,
  output logic [CNT_W-1:0] count
);
  cntStrobe_t strobe;
  logic cntLast, running, toMode;

  rx_gap_timer_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .startCmd(startCmd),
    .stopCmd(stopCmd), .toOnCmd(toOnCmd), .toOffCmd(toOffCmd),
    .charXfer(charXfer), .readyClr(readyClr), .cntLast(cntLast),
    .strobe(strobe), .ready(ready), .running(running), .toMode(toMode)
  );

  rx_gap_timer_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preload(preload),
    .count(count), .cntLast(cntLast)
  );
endmodule

// File: rtl/rx_gap_timer_chk.sv
module rx_gap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             startCmd,
  input logic             stopCmd,
  input logic             toOnCmd,
  input logic             charXfer,
  input logic             readyClr,
  input logic             ready,
  input logic             running,
  input logic             toMode,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_TICKLESS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !startCmd && !charXfer) |=> count == $past(count)); // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (running && tick && count > ONE && !startCmd && !stopCmd && !charXfer && !toOnCmd)
      |=> count == $past(count) - ONE); // R2

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (!toMode && stopCmd && !toOnCmd) |=> (!running && !ready)); // R4

  AST_TO_ON_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    toOnCmd |=> (!ready && !running && toMode)); // R5

  AST_TO_IGNORES_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (toMode && running && stopCmd && !toOnCmd && !tick) |=> running); // R6

  AST_TO_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    (toMode && running && tick && count <= ONE && !charXfer && !toOnCmd)
      |=> (ready && count == '0 && !running)); // R8

  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (readyClr && !(running && tick && count <= ONE)) |=> !ready); // R10
endmodule

bind rx_gap_timer rx_gap_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .startCmd(startCmd),
  .stopCmd(stopCmd), .toOnCmd(toOnCmd), .charXfer(charXfer),
  .readyClr(readyClr), .ready(ready), .running(running),
  .toMode(toMode), .count(count)
);

// File: tb/test_rx_gap_timer.sv
module test_rx_gap_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, startCmd = 1'b0, stopCmd = 1'b0, toOnCmd = 1'b0;
  logic toOffCmd = 1'b0, charXfer = 1'b0, readyClr = 1'b0;
  logic [W-1:0] pre = '0;
  logic ready;
  logic [W-1:0] count;

  int vecs = 0;
  int errs = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] mCnt = '0;
  logic mRun = 0, mRdy = 0, mTo = 0;

  rx_gap_timer #(.CNT_W(W)) i_rx_gap_timer (
    .clk(clk), .rstN(rstN), .tick(tick), .preload(pre),
    .startCmd(startCmd), .stopCmd(stopCmd), .toOnCmd(toOnCmd),
    .toOffCmd(toOffCmd), .charXfer(charXfer), .readyClr(readyClr),
    .ready(ready), .count(count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errs = errs + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic compare(input string tag);
    vecs++;
    if (count !== mCnt || ready !== mRdy) begin
      errs++;
      $display("FAIL %s: actual count=%0d ready=%0b, expected count=%0d ready=%0b",
               tag, count, ready, mCnt, mRdy);
    end
  endtask

  task automatic modelStep();
    logic fire;
    fire = 0;
    if (toOnCmd) begin
      mTo = 1; mRun = 0; mRdy = 0;
    end else begin
      if (!mTo && stopCmd) begin
        mRun = 0; mRdy = 0;
      end else if (!mTo && startCmd) begin
        mCnt = pre; mRun = 1;
      end else if (mTo && charXfer) begin
        mCnt = pre; mRun = 1;
      end else if (mRun && tick) begin
        if (mCnt <= 1) begin
          fire = 1; mRdy = 1;
          if (mTo) begin mCnt = 0; mRun = 0; end
          else mCnt = pre;
        end else begin
          mCnt = mCnt - 1;
        end
      end
      if (readyClr && !fire) mRdy = 0;
      if (toOffCmd) mTo = 0;
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    modelStep();
    #1 compare(tag);
    @(negedge clk);
    tick = 0; startCmd = 0; stopCmd = 0; toOnCmd = 0;
    toOffCmd = 0; charXfer = 0; readyClr = 0;
  endtask

  task automatic run(input int n, input int every, input string tag);
    for (int i = 0; i < n; i++) begin
      tick = ((i % every) == 0);
      cyc(tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc("R1");
    run(3, 1, "R1");

    // R2 / R3: normal mode sweep over preloads and tick spacings
    for (int p = 0; p < 7; p++) begin
      for (int e = 1; e <= 3; e++) begin
        pre = W'(p);
        startCmd = 1; cyc("R2");
        run(e * (2 * p + 3), e, "R3");
        readyClr = 1; cyc("R10");
        stopCmd = 1; cyc("R4");
      end
    end

    // R4: stop mid count, then stop beats start
    pre = 4'd9; startCmd = 1; cyc("R2");
    run(3, 1, "R2");
    stopCmd = 1; tick = 1; cyc("R4");
    run(4, 1, "R4");
    startCmd = 1; stopCmd = 1; cyc("R4");
    run(3, 1, "R4");
    // stop clears pending ready
    pre = 4'd2; startCmd = 1; cyc("R2");
    run(3, 1, "R3");
    stopCmd = 1; cyc("R4");

    // R5: timeout-on overrides start, tick and clears ready
    startCmd = 1; cyc("R2");
    run(3, 1, "R3");
    toOnCmd = 1; startCmd = 1; tick = 1; toOffCmd = 1; cyc("R5");
    run(4, 1, "R5");

    // R6: start/stop ignored in timeout mode
    startCmd = 1; cyc("R6");
    run(2, 1, "R6");
    stopCmd = 1; cyc("R6");

    // R7 / R8: character reload sweep with varied gaps
    for (int p = 1; p < 6; p++) begin
      pre = W'(p);
      for (int g = 0; g < 8; g++) begin
        charXfer = 1; cyc("R7");
        run(g, 1, "R8");
      end
      run(p + 3, 1, "R8");
      readyClr = 1; cyc("R10");
    end
    pre = 4'd6; charXfer = 1; cyc("R7");
    stopCmd = 1; tick = 1; cyc("R6");
    startCmd = 1; tick = 1; cyc("R6");
    run(8, 1, "R8");

    // R10: clear coincident with timeout expiry
    pre = 4'd2; charXfer = 1; cyc("R7");
    tick = 1; cyc("R8");
    tick = 1; readyClr = 1; cyc("R10");
    run(2, 1, "R10");

    // R9: timeout-off keeps run and pending ready
    pre = 4'd1; charXfer = 1; cyc("R7");
    tick = 1; cyc("R8");
    pre = 4'd5; charXfer = 1; cyc("R7");
    toOffCmd = 1; tick = 1; cyc("R9");
    run(12, 1, "R9");
    startCmd = 1; pre = 4'd3; cyc("R9");
    run(5, 1, "R9");
    stopCmd = 1; cyc("R9");

    // R7: character pulses ignored in normal mode
    pre = 4'd7;
    charXfer = 1; tick = 1; cyc("R7");
    run(3, 1, "R7");
    startCmd = 1; cyc("R2");
    run(2, 1, "R2");
    charXfer = 1; tick = 1; cyc("R7");
    run(10, 2, "R3");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule